// File: doc/BRIEF.md
# Single-Bit ECC Spare-Byte Packer

This block sits beside a NAND page-program datapath. For every 512-byte sector of a page, an external parity engine produces a 32-bit raw parity word. The packer turns that word into a 24-bit single-bit-correcting code and writes it into a spare-area buffer as three bytes. The buffer is addressed by byte index, one byte per cycle.

The code takes two separated 12-bit fields of the raw word and is stored inverted. As a result, a sector that reads back as all 0xFF carries a matching all-ones code. Codes start at a base offset that depends on the page size, and successive sectors follow on without gaps.

A page-start pulse selects the page size. It first paints the whole spare area with 0xFF, so every byte that never receives a code reads as erased. Sector strobes that arrive while the block is writing are dropped. Strobes that arrive after the page's last sector are dropped and raise a sticky overflow flag.

Top module: `ecc1_spare_packer`

## Requirements
- R1: The 24-bit code takes raw bits [11:0] as code bits [11:0] and raw bits [27:16] as code bits [23:12]. Raw bits [15:12] and [31:28] have no effect on the written bytes.
- R2: Every code bit is written inverted. A raw word of zero therefore yields the bytes 0xFF, 0xFF, 0xFF.
- R3: The three bytes of a code are written least-significant byte first, on three consecutive cycles, to three consecutive increasing indices.
- R4: The page_sel encoding is: 0 for a 512-byte page (spare 16 bytes, 1 sector, first code at index 0); 1 for a 2048-byte page (spare 64, 4 sectors, index 40); 2 or 3 for a 4096-byte page (spare 128, 8 sectors, index 80).
- R5: Sector k of a page (counting from 0) has its code at base + 3k.
- R6: A page_start pulse writes 0xFF to every spare index from 0 to size-1, one per cycle, in ascending order, with busy high throughout. It also resets the sector count, the write pointer and overflow.
- R7: A sect_done in idle after the page's last sector causes no write. It sets overflow, which stays set until the next page_start.
- R8: wr_valid is high for exactly one cycle per byte written. A sect_done that arrives while busy is high causes no write and does not use up a sector slot.
- R9: After reset, wr_valid, busy and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Begin a new page: latch page_sel, fill the spare area with 0xFF |
| page_sel | input | 2 | Page size select (0: 512, 1: 2048, 2/3: 4096) |
| sect_done | input | 1 | Raw parity for the next sector is valid this cycle |
| raw_par | input | 32 | Raw parity word of the sector |
| wr_valid | output | 1 | Spare-byte write strobe |
| wr_idx | output | 7 | Spare-area byte index of the write |
| wr_byte | output | 8 | Byte value to write |
| busy | output | 1 | Fill or code emission in progress; strobes are dropped |
| overflow | output | 1 | Sticky: a strobe arrived after the page's last sector |

## Verification
On every cycle, the embedded properties check four things. Write indices stay inside the selected spare area. Bytes of one code land on consecutive indices. The sector count never exceeds the page's sector count and does not move while the block is busy. Overflow holds until a page start.

Only the bench scenarios can show the byte values themselves. These are the field extraction, the inversion, the byte order and the per-page base offsets. The bench scenarios also show that the fill covers exactly the spare area, and that dropped strobes leave the buffer untouched. These are checked against a byte model of the spare buffer built from the write stream.

// File: rtl/ecc1_pack_pkg.sv
package ecc1_pack_pkg;
  localparam int IDX_W    = 7;   // spare index width (up to 128 bytes)
  localparam int CNT_W    = 4;   // sector counter width (up to 8 sectors)
  localparam int CODE_BYTES = 3;
  localparam int BC_W     = $clog2(CODE_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_EMIT} pk_state_e;

  function automatic logic [IDX_W-1:0] base_of(input logic [1:0] sel);
    case (sel)
      2'd0:    base_of = IDX_W'(0);
      2'd1:    base_of = IDX_W'(40);
      default: base_of = IDX_W'(80);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] last_of(input logic [1:0] sel);
    case (sel)
      2'd0:    last_of = IDX_W'(15);
      2'd1:    last_of = IDX_W'(63);
      default: last_of = IDX_W'(127);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] nsect_of(input logic [1:0] sel);
    case (sel)
      2'd0:    nsect_of = CNT_W'(1);
      2'd1:    nsect_of = CNT_W'(4);
      default: nsect_of = CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/ecc1_code_fmt.sv
module ecc1_code_fmt #(
  parameter int RAW_W  = 32,
  parameter int HALF_W = 12,
  parameter int HI_LSB = 16,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] joined;
  logic              unused_bits;

  assign joined      = {raw[HI_LSB +: HALF_W], raw[HALF_W-1:0]};
  assign code        = ~joined;
  assign unused_bits = ^{raw[HI_LSB-1:HALF_W], raw[RAW_W-1:HI_LSB+HALF_W]};
endmodule

// File: rtl/ecc1_seq_ctrl.sv
module ecc1_seq_ctrl
  import ecc1_pack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_start,
  input  logic [1:0]       page_sel,
  input  logic             sect_done,
  output pk_state_e        st,
  output logic [IDX_W-1:0] idx,
  output logic [BC_W-1:0]  bcnt,
  output logic             load,
  output logic             ovf
);
  pk_state_e        st_q, st_d;
  logic [1:0]       sel_q, sel_d;
  logic [IDX_W-1:0] wptr_q, wptr_d, fill_q, fill_d;
  logic [BC_W-1:0]  bcnt_q, bcnt_d;
  logic [CNT_W-1:0] scnt_q, scnt_d;
  logic             ovf_q, ovf_d;
  logic             en;

  always_comb begin
    st_d = st_q; sel_d = sel_q; wptr_d = wptr_q; fill_d = fill_q;
    bcnt_d = bcnt_q; scnt_d = scnt_q; ovf_d = ovf_q; load = 1'b0;
    if (page_start) begin
      st_d   = ST_FILL;
      sel_d  = page_sel;
      wptr_d = base_of(page_sel);
      fill_d = '0;
      bcnt_d = '0;
      scnt_d = '0;
      ovf_d  = 1'b0;
    end else begin
      case (st_q)
        ST_FILL: begin
          fill_d = fill_q + 1'b1;
          if (fill_q == last_of(sel_q)) st_d = ST_IDLE;
        end
        ST_EMIT: begin
          wptr_d = wptr_q + 1'b1;
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == BC_W'(CODE_BYTES - 1)) begin
            st_d   = ST_IDLE;
            bcnt_d = '0;
          end
        end
        default: begin
          if (sect_done) begin
            if (scnt_q == nsect_of(sel_q)) begin
              ovf_d = 1'b1;
            end else begin
              load   = 1'b1;
              st_d   = ST_EMIT;
              scnt_d = scnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign en = page_start | sect_done | (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sel_q <= 2'd0; wptr_q <= '0; fill_q <= '0;
      bcnt_q <= '0; scnt_q <= '0; ovf_q <= 1'b0;
    end else if (en) begin
      st_q <= st_d; sel_q <= sel_d; wptr_q <= wptr_d; fill_q <= fill_d;
      bcnt_q <= bcnt_d; scnt_q <= scnt_d; ovf_q <= ovf_d;
    end
  end

  assign st   = st_q;
  assign idx  = (st_q == ST_FILL) ? fill_q : wptr_q;
  assign bcnt = bcnt_q;
  assign ovf  = ovf_q;

  p_idx_in_spare_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (idx <= last_of(sel_q)));
  p_sect_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scnt_q <= nsect_of(sel_q));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !page_start) |=> ovf_q);
  p_busy_no_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !page_start) |=> $stable(scnt_q));
  p_consec_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EMIT && !page_start && bcnt_q != BC_W'(CODE_BYTES - 1))
      |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/ecc1_spare_packer.sv
module ecc1_spare_packer
  import ecc1_pack_pkg::*;
#(
  parameter int RAW_W  = 32,
  parameter int HALF_W = 12,
  localparam int CODE_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_start,
  input  logic [1:0]       page_sel,
  input  logic             sect_done,
  input  logic [RAW_W-1:0] raw_par,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_byte,
  output logic             busy,
  output logic             overflow
);
  pk_state_e         st;
  logic [BC_W-1:0]   bcnt;
  logic              load;
  logic [CODE_W-1:0] code_w, code_q;
  logic [7:0]        emit_byte;

  ecc1_code_fmt #(.RAW_W(RAW_W), .HALF_W(HALF_W), .HI_LSB(16)) u_fmt (
    .raw (raw_par),
    .code(code_w)
  );

  ecc1_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_start(page_start),
    .page_sel  (page_sel),
    .sect_done (sect_done),
    .st        (st),
    .idx       (wr_idx),
    .bcnt      (bcnt),
    .load      (load),
    .ovf       (overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (load)  code_q <= code_w;
  end

  always_comb begin
    emit_byte = 8'h00;
    for (int b = 0; b < CODE_BYTES; b++)
      if (bcnt == BC_W'(b)) emit_byte = code_q[b*8 +: 8];
  end

  assign wr_valid = (st != ST_IDLE);
  assign busy     = (st != ST_IDLE);
  assign wr_byte  = (st == ST_FILL) ? 8'hFF : emit_byte;

  p_load_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wr_valid && $past(!busy)));
endmodule

// File: tb/tb_ecc1_spare_packer.sv
`timescale 1ns/1ps
module tb_ecc1_spare_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_start = 1'b0;
  logic [1:0]  page_sel = 2'd0;
  logic        sect_done = 1'b0;
  logic [31:0] raw_par = '0;
  logic        wr_valid, busy, overflow;
  logic [6:0]  wr_idx;
  logic [7:0]  wr_byte;

  int n_chk = 0, n_bad = 0, n_wr = 0, cyc = 0;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];

  always #2.5 clk = ~clk;

  ecc1_spare_packer dut (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_sel(page_sel),
    .sect_done(sect_done), .raw_par(raw_par), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_byte(wr_byte), .busy(busy), .overflow(overflow));

  always @(posedge clk) begin
    cyc++;
    if (wr_valid) begin
      mem[wr_idx] <= wr_byte;
      n_wr++;
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int spare_sz(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 64 : 128;
  endfunction
  function automatic int base_ix(input logic [1:0] s);
    return (s == 2'd0) ? 0 : (s == 2'd1) ? 40 : 80;
  endfunction
  // R1/R2: low field unchanged, high field moved down, all inverted
  function automatic logic [23:0] exp_code(input logic [31:0] r);
    return ~{r[27:16], r[11:0]};
  endfunction

  task automatic start_page(input logic [1:0] s);
    int fc = 0;
    for (int i = 0; i < 128; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    for (int i = 0; i < spare_sz(s); i++) exp_mem[i] = 8'hFF;
    n_wr = 0;
    @(negedge clk); page_start = 1'b1; page_sel = s;
    @(negedge clk); page_start = 1'b0;
    while (busy && fc < 300) begin fc++; @(negedge clk); end
    chk("R6 fill cycles", fc, spare_sz(s));
    chk("R6 overflow cleared", overflow, 0);
  endtask

  // send one strobe; return number of busy cycles that followed
  task automatic send_sector(input logic [31:0] r, output int bc);
    bc = 0;
    sect_done = 1'b1; raw_par = r;
    @(negedge clk); sect_done = 1'b0;
    while (busy && bc < 10) begin bc++; @(negedge clk); end
  endtask

  task automatic put_exp(input int pos, input logic [31:0] r);
    logic [23:0] c = exp_code(r);
    exp_mem[pos] = c[7:0]; exp_mem[pos+1] = c[15:8]; exp_mem[pos+2] = c[23:16];
  endtask

  task automatic cmp_mem(input string req);
    for (int i = 0; i < 128; i++) chk(req, mem[i], exp_mem[i]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 valid at reset", wr_valid, 0);
    chk("R9 busy at reset", busy, 0);
    chk("R9 overflow at reset", overflow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after release", busy, 0);
  endtask

  task automatic t_full_page(input logic [1:0] s, input logic [31:0] seed);
    int n = (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 8;
    int bc;
    start_page(s);
    for (int k = 0; k < n; k++) begin
      logic [31:0] r = seed ^ (32'h1357_9BDF * (k + 1));
      send_sector(r, bc);
      chk("R8 three valid cycles", bc, 3);
      put_exp(base_ix(s) + 3 * k, r);     // R3 R4 R5 placement
    end
    chk("R8 write count", n_wr, spare_sz(s) + 3 * n);
    cmp_mem("R5 page layout");
  endtask

  task automatic t_fields();
    int bc;
    start_page(2'd0);
    send_sector(32'hF000_F000, bc);        // R1 ignored bits, R2 zero -> FF
    chk("R1 byte0", mem[0], 8'hFF);
    chk("R1 byte1", mem[1], 8'hFF);
    chk("R2 byte2", mem[2], 8'hFF);
    start_page(2'd0);
    send_sector(32'h0ABC_0123, bc);        // code ~0xABC123 = 0x543EDC
    chk("R3 lsb first", mem[0], 8'hDC);
    chk("R3 middle", mem[1], 8'h3E);
    chk("R3 msb last", mem[2], 8'h54);
    chk("R6 next byte erased", mem[3], 8'hFF);
  endtask

  task automatic t_overflow();
    int bc;
    start_page(2'd0);
    send_sector(32'h1234_5678, bc);
    put_exp(0, 32'h1234_5678);
    send_sector(32'h0000_0000, bc);
    chk("R7 no write on extra strobe", bc, 0);
    chk("R7 overflow set", overflow, 1);
    repeat (3) @(negedge clk);
    chk("R7 overflow sticky", overflow, 1);
    chk("R7 write count", n_wr, 16 + 3);
    cmp_mem("R7 buffer untouched");
    start_page(2'd1);
  endtask

  task automatic t_busy_drop();
    int bc;
    start_page(2'd1);
    sect_done = 1'b1; raw_par = 32'h0111_0222;
    @(negedge clk); raw_par = 32'h0FFF_0FFF;   // still high while busy: dropped
    @(negedge clk); sect_done = 1'b0;
    while (busy) @(negedge clk);
    put_exp(40, 32'h0111_0222);
    send_sector(32'h0333_0444, bc);
    put_exp(43, 32'h0333_0444);
    chk("R8 dropped strobe writes", n_wr, 64 + 6);
    cmp_mem("R8 slot not consumed");
  endtask

  initial begin
    t_reset();
    t_fields();
    t_full_page(2'd0, 32'hDEAD_BEEF);
    t_full_page(2'd1, 32'h0F0F_5A5A);
    t_full_page(2'd2, 32'h8001_7FFE);
    t_full_page(2'd3, 32'h2468_ACE0);      // R4: code 3 behaves as 4096
    t_overflow();
    t_busy_drop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule